// File: doc/BRIEF.md
# Regulator Control Register Bank

This block holds the configuration of a digitally controlled step-down regulator. A serial bus slave that has already decoded its framing presents single-byte register writes and reads on a plain port (`wr_en`, `addr`, `wdata`, `rdata`). The bank keeps the output-voltage code, the mode bit that chooses between the internal code and an external resistor divider, and the enable bit. It also keeps the option fields for fault blanking, reference settling speed, current limit, hiccup restart and the two latch-off disables. Every selected code is exported as a registered output for the analog side.

The voltage register takes a write only when the byte carries odd parity. Bits 6:0 hold the voltage code and bit 7 is the check bit. An accepted write also switches the regulator to internal-code mode. The effective enable is the enable bit ORed with an external pin. A blanking counter holds back the power-good pulldown until a fault has persisted for a code-selected number of base intervals. One base interval is `BASE_TICKS` clock cycles.

Top module: `vrb_regbank`

## Requirements
- R1: After reset the register at address 0 reads 0x32, address 8 reads 0x1C, address 9 reads 0x0F and address 24 reads 0x07. `rdata` shows the register selected by `addr` one clock edge after `addr` is presented.
- R2: A write to address 0 is accepted only when the count of ones in the 8-bit `wdata` is odd. Once accepted, `vcode` equals `wdata[6:0]` and address 0 reads back the whole byte. The stored byte always has odd parity.
- R3: A write to address 0 with even parity leaves address 0, the internal-mode bit and the enable bit unchanged.
- R4: An accepted write to address 0 sets the internal-mode bit (address 8 bit 1, output `int_mode`) on the same edge.
- R5: Writing address 8 with bit 1 at 0 clears the internal-mode bit at any time.
- R6: `en_out` equals the enable bit (address 8 bit 0) ORed with `ext_en`, registered one edge later. Writing 0 to the bit cannot turn `en_out` off while `ext_en` is high.
- R7: Address 8 bits 3:2 select the blanking delay D: code 00 gives 0 cycles, 01 gives `BASE_TICKS`, 10 gives 2x and 11 gives 4x. `pg_pull` rises after D+1 consecutive clock edges that sample `fault` high.
- R8: If `fault` falls before the delay expires, the count restarts from zero and `pg_pull` stays low. After `fault` falls, `pg_pull` is low from the next edge.
- R9: Rewriting address 8 bits 3:2 disturbs no other field. Writes to address 9 or 24 leave address 8 unchanged.
- R10: Address 8 bit 4 is hiccup and bit 5 is eco-mode. Address 9 bits 1:0 are settle speed, bit 2 is the overvoltage latch-off disable and bit 3 is the undervoltage latch-off disable. Address 24 bits 2:0 are the current limit. The outputs mirror these fields, and unused bits read as 0.
- R11: Writes to any other address change nothing, and reads from such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr`/`wdata` |
| addr | input | 8 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ext_en | input | 1 | External enable pin |
| fault | input | 1 | Synchronous power-good fault indication |
| pg_pull | output | 1 | Power-good pulldown request |
| en_out | output | 1 | Effective regulator enable |
| int_mode | output | 1 | 1 = internal voltage code, 0 = external divider |
| vcode | output | 7 | Selected voltage code |
| dac_settle | output | 2 | Reference settling speed code |
| ilim | output | 3 | Current-limit code |
| hiccup_en | output | 1 | Hiccup restart enable |
| eco_en | output | 1 | Light-load skip mode enable |
| ovp_latch_dis | output | 1 | Overvoltage latch-off disable |
| uvp_latch_dis | output | 1 | Undervoltage latch-off disable |

## Verification
A wrong stored bit appears on the matching export pin at the next edge and in `rdata` one edge after its address is presented. A parity slip therefore shows at once as a changed `vcode` or a flipped `int_mode` after a rejected byte. A faulty blanking counter appears only as a `pg_pull` edge that is early or late by some cycles compared with the D+1 count for each delay code. A missed restart shows up only when `fault` drops out partway through a window and returns. The bench therefore counts edges to the pulldown for all four codes and repeats the interrupted case.

// File: rtl/vrb_pkg.sv
package vrb_pkg;
  localparam int DW = 8;
  localparam int AW = 8;

  localparam logic [AW-1:0] ADR_VOUT = 8'd0;
  localparam logic [AW-1:0] ADR_CTLA = 8'd8;
  localparam logic [AW-1:0] ADR_CTLB = 8'd9;
  localparam logic [AW-1:0] ADR_CTLC = 8'd24;

  localparam int A_EN  = 0;
  localparam int A_INT = 1;
  localparam int A_PGD = 2;
  localparam int A_HIC = 4;
  localparam int A_ECO = 5;
  localparam int B_DAC = 0;
  localparam int B_OVP = 2;
  localparam int B_UVP = 3;
  localparam int C_ILM = 0;

  localparam logic [DW-1:0] VOUT_RST = 8'h32;

  typedef struct packed {
    logic       en_bit;
    logic       int_mode;
    logic [1:0] pgd;
    logic       hiccup;
    logic       eco;
    logic [1:0] dac;
    logic       ovp_dis;
    logic       uvp_dis;
    logic [2:0] ilim;
  } ctl_t;

  localparam ctl_t CTL_RST = '{en_bit: 1'b0, int_mode: 1'b0, pgd: 2'b11,
                               hiccup: 1'b1, eco: 1'b0, dac: 2'b11,
                               ovp_dis: 1'b1, uvp_dis: 1'b1, ilim: 3'b111};

  function automatic logic [DW-1:0] pack_a(ctl_t c);
    logic [DW-1:0] v;
    v = '0;
    v[A_EN] = c.en_bit;
    v[A_INT] = c.int_mode;
    v[A_PGD +: 2] = c.pgd;
    v[A_HIC] = c.hiccup;
    v[A_ECO] = c.eco;
    return v;
  endfunction

  function automatic logic [DW-1:0] pack_b(ctl_t c);
    logic [DW-1:0] v;
    v = '0;
    v[B_DAC +: 2] = c.dac;
    v[B_OVP] = c.ovp_dis;
    v[B_UVP] = c.uvp_dis;
    return v;
  endfunction

  function automatic logic [DW-1:0] pack_c(ctl_t c);
    logic [DW-1:0] v;
    v = '0;
    v[C_ILM +: 3] = c.ilim;
    return v;
  endfunction
endpackage

// File: rtl/vrb_vout_reg.sv
module vrb_vout_reg
  import vrb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] vout_q,
  output logic          accept
);
  logic par_odd;

  assign par_odd = ^wdata;
  assign accept  = wr_sel && par_odd;

  always_ff @(posedge clk) begin
    if (rst) vout_q <= VOUT_RST;
    else if (accept) vout_q <= wdata;
  end

  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && !(^wdata)) |=> (vout_q == $past(vout_q)));

  assert_stored_odd_R2: assert property (@(posedge clk) disable iff (rst)
    (^vout_q) == 1'b1);
endmodule

// File: rtl/vrb_ctl_regs.sv
module vrb_ctl_regs
  import vrb_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_a,
  input  logic          wr_b,
  input  logic          wr_c,
  input  logic          set_int,
  input  logic [DW-1:0] wdata,
  output ctl_t          cfg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= CTL_RST;
    end else begin
      if (wr_a) begin
        cfg.en_bit   <= wdata[A_EN];
        cfg.int_mode <= wdata[A_INT];
        cfg.pgd      <= wdata[A_PGD +: 2];
        cfg.hiccup   <= wdata[A_HIC];
        cfg.eco      <= wdata[A_ECO];
      end
      if (set_int) cfg.int_mode <= 1'b1;
      if (wr_b) begin
        cfg.dac     <= wdata[B_DAC +: 2];
        cfg.ovp_dis <= wdata[B_OVP];
        cfg.uvp_dis <= wdata[B_UVP];
      end
      if (wr_c) cfg.ilim <= wdata[C_ILM +: 3];
    end
  end

  assert_int_set_R4: assert property (@(posedge clk) disable iff (rst)
    set_int |=> cfg.int_mode);

  assert_int_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_a && !wdata[A_INT] && !set_int) |=> !cfg.int_mode);

  assert_a_isolated_R9: assert property (@(posedge clk) disable iff (rst)
    ((wr_b || wr_c) && !wr_a && !set_int) |=>
      ($stable(cfg.pgd) && $stable(cfg.hiccup) && $stable(cfg.eco) && $stable(cfg.en_bit)));

  assert_en_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (!wr_a) |=> $stable(cfg.en_bit));
endmodule

// File: rtl/vrb_pg_blank.sv
module vrb_pg_blank #(
  parameter int BASE_TICKS = 1320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fault,
  input  logic [1:0] code,
  output logic       pull
);
  localparam int MAX_TICKS = 4 * BASE_TICKS;
  localparam int CW = $clog2(MAX_TICKS + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  always_comb begin
    case (code)
      2'b00:   target = '0;
      2'b01:   target = CW'(BASE_TICKS);
      2'b10:   target = CW'(2 * BASE_TICKS);
      default: target = CW'(MAX_TICKS);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pull <= 1'b0;
    end else if (!fault) begin
      cnt  <= '0;
      pull <= 1'b0;
    end else if (cnt >= target) begin
      pull <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      pull <= 1'b0;
    end
  end

  assert_release_R8: assert property (@(posedge clk) disable iff (rst)
    !fault |=> !pull);

  assert_pull_after_fault_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(pull) |-> $past(fault));

  assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(MAX_TICKS));
endmodule

// File: rtl/vrb_regbank.sv
module vrb_regbank
  import vrb_pkg::*;
#(
  parameter int BASE_TICKS = 1320
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ext_en,
  input  logic       fault,
  output logic       pg_pull,
  output logic       en_out,
  output logic       int_mode,
  output logic [6:0] vcode,
  output logic [1:0] dac_settle,
  output logic [2:0] ilim,
  output logic       hiccup_en,
  output logic       eco_en,
  output logic       ovp_latch_dis,
  output logic       uvp_latch_dis
);
  logic          sel_v, sel_a, sel_b, sel_c;
  logic          v_accept;
  logic [DW-1:0] vout_q;
  logic [DW-1:0] rd_mux;
  ctl_t          cfg;

  assign sel_v = wr_en && (addr == ADR_VOUT);
  assign sel_a = wr_en && (addr == ADR_CTLA);
  assign sel_b = wr_en && (addr == ADR_CTLB);
  assign sel_c = wr_en && (addr == ADR_CTLC);

  vrb_vout_reg u_vout (
    .clk(clk), .rst(rst), .wr_sel(sel_v), .wdata(wdata),
    .vout_q(vout_q), .accept(v_accept)
  );

  vrb_ctl_regs u_ctl (
    .clk(clk), .rst(rst), .wr_a(sel_a), .wr_b(sel_b), .wr_c(sel_c),
    .set_int(v_accept), .wdata(wdata), .cfg(cfg)
  );

  vrb_pg_blank #(.BASE_TICKS(BASE_TICKS)) u_pg (
    .clk(clk), .rst(rst), .fault(fault), .code(cfg.pgd), .pull(pg_pull)
  );

  always_comb begin
    case (addr)
      ADR_VOUT: rd_mux = vout_q;
      ADR_CTLA: rd_mux = pack_a(cfg);
      ADR_CTLB: rd_mux = pack_b(cfg);
      ADR_CTLC: rd_mux = pack_c(cfg);
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      en_out <= 1'b0;
    end else begin
      rdata  <= rd_mux;
      en_out <= cfg.en_bit | ext_en;
    end
  end

  assign vcode         = vout_q[DW-2:0];
  assign int_mode      = cfg.int_mode;
  assign dac_settle    = cfg.dac;
  assign ilim          = cfg.ilim;
  assign hiccup_en     = cfg.hiccup;
  assign eco_en        = cfg.eco;
  assign ovp_latch_dis = cfg.ovp_dis;
  assign uvp_latch_dis = cfg.uvp_dis;

  assert_pin_forces_en_R6: assert property (@(posedge clk) disable iff (rst)
    ext_en |=> en_out);

  assert_accept_sets_int_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADR_VOUT && (^wdata)) |=> int_mode);

  assert_undef_reads_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (addr != ADR_VOUT && addr != ADR_CTLA && addr != ADR_CTLB && addr != ADR_CTLC)
      |=> (rdata == '0));
endmodule

// File: tb/vrb_regbank_tb.sv
module vrb_regbank_tb_top;
  localparam int BT = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       ext_en = 1'b0;
  logic       fault = 1'b0;
  logic [7:0] rdata;
  logic       pg_pull, en_out, int_mode, hiccup_en, eco_en, ovp_latch_dis, uvp_latch_dis;
  logic [6:0] vcode;
  logic [1:0] dac_settle;
  logic [2:0] ilim;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  vrb_regbank #(.BASE_TICKS(BT)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ext_en(ext_en), .fault(fault), .pg_pull(pg_pull), .en_out(en_out),
    .int_mode(int_mode), .vcode(vcode), .dac_settle(dac_settle), .ilim(ilim),
    .hiccup_en(hiccup_en), .eco_en(eco_en), .ovp_latch_dis(ovp_latch_dis),
    .uvp_latch_dis(uvp_latch_dis)
  );

  // {addr, wdata, expected read of addr after the write}
  localparam logic [23:0] VEC [12] = '{
    {8'd0,   8'h05, 8'h32},  // R3 even parity rejected
    {8'd0,   8'h85, 8'h85},  // R2 odd accepted
    {8'd0,   8'h7F, 8'h7F},  // R2
    {8'd0,   8'hFF, 8'h7F},  // R3
    {8'd8,   8'h3F, 8'h3F},  // R10
    {8'd8,   8'hC0, 8'h00},  // R10 unused bits
    {8'd9,   8'hFF, 8'h0F},  // R10
    {8'd24,  8'hFD, 8'h05},  // R10
    {8'd5,   8'hFF, 8'h00},  // R11
    {8'd255, 8'hAA, 8'h00},  // R11
    {8'd0,   8'h00, 8'h7F},  // R3
    {8'd0,   8'h80, 8'h80}   // R2
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fault = 1'b0; ext_en = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic measure(input logic [1:0] code, input int exp_edges);
    int n;
    wr(8'd8, {2'b00, 2'b01, code, 2'b00});
    @(negedge clk);
    fault = 1'b1;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (pg_pull) break;
    end
    check("R7 edges to pulldown", n, exp_edges);
    fault = 1'b0;
    @(negedge clk);
    check("R8 release after fault drop", pg_pull, 1'b0);
  endtask

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 reset values and exports
    rd(8'd0, d);  check("R1 addr0", d, 8'h32);
    rd(8'd8, d);  check("R1 addr8", d, 8'h1C);
    rd(8'd9, d);  check("R1 addr9", d, 8'h0F);
    rd(8'd24, d); check("R1 addr24", d, 8'h07);
    check("R1 vcode", vcode, 7'h32);
    check("R1 int_mode", int_mode, 1'b0);
    check("R1 exports", {hiccup_en, eco_en, ovp_latch_dis, uvp_latch_dis, dac_settle, ilim},
          {1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 3'b111});
    check("R1 pg_pull/en_out", {pg_pull, en_out}, 2'b00);

    for (int i = 0; i < 12; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(VEC[i][23:16], d);
      check("R2/R3/R10/R11 table", d, VEC[i][7:0]);
    end
    check("R10 ilim export", ilim, 3'b101);
    check("R10 latch/dac exports", {ovp_latch_dis, uvp_latch_dis, dac_settle}, 4'b1111);
    check("R2 vcode export", vcode, 7'h00);

    // R4 / R5 / R3 side effects
    do_reset();
    wr(8'd0, 8'h85);
    check("R4 int_mode set", int_mode, 1'b1);
    check("R2 vcode", vcode, 7'h05);
    wr(8'd8, 8'h1C);
    check("R5 int_mode cleared", int_mode, 1'b0);
    wr(8'd0, 8'h03);
    check("R3 int_mode unchanged", int_mode, 1'b0);
    rd(8'd8, d); check("R3 enable bit unchanged", d[0], 1'b0);
    check("R3 vcode unchanged", vcode, 7'h05);

    // R6 enable combination
    @(negedge clk); ext_en = 1'b1;
    @(negedge clk); check("R6 pin enables", en_out, 1'b1);
    ext_en = 1'b0;
    @(negedge clk); check("R6 pin low", en_out, 1'b0);
    wr(8'd8, 8'h1D);
    @(negedge clk); check("R6 bit enables", en_out, 1'b1);
    ext_en = 1'b1;
    wr(8'd8, 8'h1C);
    @(negedge clk); check("R6 writing 0 with pin high", en_out, 1'b1);
    ext_en = 1'b0;
    @(negedge clk); @(negedge clk); check("R6 both low", en_out, 1'b0);

    // R7 delay per code
    measure(2'b00, 1);
    measure(2'b01, BT + 1);
    measure(2'b10, 2 * BT + 1);
    measure(2'b11, 4 * BT + 1);

    // R8 interrupted fault restarts the count
    wr(8'd8, 8'h1C);
    @(negedge clk); fault = 1'b1;
    begin
      int hi;
      hi = 0;
      for (int i = 0; i < 4 * BT - 5; i++) begin
        @(negedge clk);
        if (pg_pull) hi++;
      end
      fault = 1'b0;
      @(negedge clk);
      fault = 1'b1;
      for (int i = 0; i < 4 * BT - 5; i++) begin
        @(negedge clk);
        if (pg_pull) hi++;
      end
      check("R8 no pulldown on interrupted fault", hi, 0);
      repeat (6) @(negedge clk);
      check("R8 pulldown after full window", pg_pull, 1'b1);
      fault = 1'b0;
    end

    // R9 field isolation
    wr(8'd8, 8'h33);
    wr(8'd9, 8'h05);
    wr(8'd24, 8'h02);
    wr(8'd8, 8'h37);
    rd(8'd8, d); check("R9 pgd rewrite keeps others", d, 8'h37);
    rd(8'd9, d); check("R9 addr9 kept", d, 8'h05);
    rd(8'd24, d); check("R9 addr24 kept", d, 8'h02);
    check("R9 eco export", eco_en, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule